// File: doc/BRIEF.md
# Host Parallel Link Bus Bridge Registers

This block is the slave end of a narrow parallel port through which a host processor drives memory-bus transactions. The host sees four 16-bit registers over a shared bidirectional data bus. It picks one with a 2-bit select and moves data with active-high write and read strobes. It loads the write data and the low address word, and then the high address word. Writing the high word launches one transaction on a downstream request/done handshake. The host polls a busy pin until the access completes. After a read it fetches the captured data through the data register.

A control register sets two bits. One holds the transaction engine idle and the other drives a downstream reset. Reading it returns the live interrupt priority level. A separate pin flags a zero interrupt level, so the host can skip that read. The host strobes are synchronised to the block clock and act on their rising edge.

Top module: `hostlink_bridge`

## Requirements
- R1: The select `hostSel` decodes 0 = data, 1 = address low, 2 = address high, 3 = control/status. At a write-strobe rising edge the selected register loads the 16-bit value on `hostData`. Reading the two address registers returns the value last loaded.
- R2: Writing the address-high register while idle raises `xferBusy` and `reqValid` three clock edges after `hostWr` rises. `reqAddr` carries address-high bits 7..0 above the 16 address-low bits.
- R3: In the address-high word, bit 8 set means a byte access (`reqByte`=1) and bit 9 set means a read (`reqWrite`=0). The data register is offered on `reqWdata`.
- R4: `reqLanes` (bit 1 = upper byte, bit 0 = lower byte) is 2'b11 for a word. For a byte it is 2'b10 at an even address and 2'b01 at an odd one.
- R5: `reqValid` and `xferBusy` stay high, with the request fields unchanged, until the cycle in which `reqDone` is sampled high. They are low on the next cycle.
- R6: When a read completes, `reqRdata` is captured into the data register. While `hostRd` is high with select 0, `hostData` carries that value.
- R7: While a transaction is busy, a write strobe to the data or either address register changes no register and starts nothing.
- R8: While `hostRd` is high with select 3, `hostData` returns `irqLevel` in bits 15..13, the reset bit in bit 1, the init bit in bit 0, and zero elsewhere.
- R9: `iplZero` is high exactly when `irqLevel` is zero.
- R10: While the init bit (control bit 0) is set, no transaction is launched. A transaction in progress is dropped on the cycle after the bit is loaded.
- R11: `busReset` follows control bit 1. Writes to the control register are accepted even while busy.
- R12: After reset, `xferBusy`, `reqValid` and `busReset` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 2 | Register select |
| hostWr | input | 1 | Write strobe, active high |
| hostRd | input | 1 | Read strobe, active high |
| hostData | inout | 16 | Shared data bus, driven by the block only while `hostRd` is high |
| xferBusy | output | 1 | Transaction in progress |
| iplZero | output | 1 | High when the interrupt level is zero |
| irqLevel | input | 3 | Current interrupt priority level |
| busReset | output | 1 | Downstream reset, from control bit 1 |
| reqValid | output | 1 | Downstream request pending |
| reqWrite | output | 1 | 1 = write, 0 = read |
| reqByte | output | 1 | 1 = byte access |
| reqLanes | output | 2 | Active byte lanes |
| reqAddr | output | 24 | Request address |
| reqWdata | output | 16 | Write data |
| reqDone | input | 1 | Downstream completion pulse |
| reqRdata | input | 16 | Downstream read data |

## Verification
A register load and a launch both land on the third rising clock edge after the write strobe rises: two synchroniser stages, then the register. The bench therefore holds each strobe for four edges and samples at a falling edge, after the load is certain. It then drops the strobe and waits three more edges so that the next rising edge is seen clean. Completion takes one edge: the bench drives `reqDone` for a single cycle and checks that busy has cleared at the following falling edge. Read data and status are combinational from the strobe, so they are sampled one nanosecond after `hostRd` rises, with no clock edge in between.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_ALO  = 2'd1,
    SEL_AHI  = 2'd2,
    SEL_CTL  = 2'd3
  } selT;

  typedef struct packed {
    logic ldData;
    logic ldLo;
    logic ldHi;
    logic ldCtl;
    logic capRd;
  } strobeT;
endpackage

// File: rtl/hostlink_ctrl.sv
module hostlink_ctrl
  import hostlink_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic [1:0] hostSel,
  input  logic       initHold,
  input  logic       reqDone,
  output strobeT     strb,
  output logic       reqValid
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] wrPipe;
  logic wrRise;
  logic accept;
  selT  sel;

  always_ff @(posedge clk) begin
    if (!rstN) wrPipe <= '0;
    else       wrPipe <= {wrPipe[PIPE_W-2:0], hostWr};
  end

  assign wrRise = wrPipe[SYNC_STAGES-1] & ~wrPipe[SYNC_STAGES];
  assign sel    = selT'(hostSel);
  assign accept = wrRise & (~reqValid | (sel == SEL_CTL));

  always_comb begin
    strb        = '0;
    strb.ldData = accept & (sel == SEL_DATA);
    strb.ldLo   = accept & (sel == SEL_ALO);
    strb.ldHi   = accept & (sel == SEL_AHI);
    strb.ldCtl  = accept & (sel == SEL_CTL);
    strb.capRd  = reqValid & reqDone & ~initHold;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           reqValid <= 1'b0;
    else if (initHold)   reqValid <= 1'b0;
    else if (strb.ldHi)  reqValid <= 1'b1;
    else if (reqDone)    reqValid <= 1'b0;
  end
endmodule

// File: rtl/hostlink_dp.sv
module hostlink_dp
  import hostlink_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24,
  parameter int IPL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] busIn,
  input  logic [IPL_W-1:0]  irqLevel,
  input  logic [DATA_W-1:0] reqRdata,
  output logic [DATA_W-1:0] rdVal,
  output logic              initHold,
  output logic              busReset,
  output logic              iplZero,
  output logic              reqWrite,
  output logic              reqByte,
  output logic [1:0]        reqLanes,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata
);
  localparam int HI_W     = ADDR_W - DATA_W;
  localparam int BYTE_BIT = HI_W;
  localparam int READ_BIT = HI_W + 1;
  localparam int PAD_W    = DATA_W - IPL_W - 2;

  logic [DATA_W-1:0] dataReg, addrLo, addrHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      addrLo   <= '0;
      addrHi   <= '0;
      initHold <= 1'b0;
      busReset <= 1'b0;
    end else begin
      if (strb.ldData) dataReg <= busIn;
      else if (strb.capRd && addrHi[READ_BIT]) dataReg <= reqRdata;
      if (strb.ldLo) addrLo <= busIn;
      if (strb.ldHi) addrHi <= busIn;
      if (strb.ldCtl) begin
        initHold <= busIn[0];
        busReset <= busIn[1];
      end
    end
  end

  assign reqAddr  = {addrHi[HI_W-1:0], addrLo};
  assign reqByte  = addrHi[BYTE_BIT];
  assign reqWrite = ~addrHi[READ_BIT];
  assign reqWdata = dataReg;
  assign reqLanes = !reqByte ? 2'b11 : (addrLo[0] ? 2'b01 : 2'b10);
  assign iplZero  = (irqLevel == '0);

  always_comb begin
    unique case (selT'(hostSel))
      SEL_DATA: rdVal = dataReg;
      SEL_ALO:  rdVal = addrLo;
      SEL_AHI:  rdVal = addrHi;
      default:  rdVal = {irqLevel, {PAD_W{1'b0}}, busReset, initHold};
    endcase
  end
endmodule

// File: rtl/hostlink_bridge.sv
module hostlink_bridge
  import hostlink_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 24,
  parameter int IPL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        hostSel,
  input  logic              hostWr,
  input  logic              hostRd,
  inout  wire  [DATA_W-1:0] hostData,
  output logic              xferBusy,
  output logic              iplZero,
  input  logic [IPL_W-1:0]  irqLevel,
  output logic              busReset,
  output logic              reqValid,
  output logic              reqWrite,
  output logic              reqByte,
  output logic [1:0]        reqLanes,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [DATA_W-1:0] reqWdata,
  input  logic              reqDone,
  input  logic [DATA_W-1:0] reqRdata
);
  strobeT            strb;
  logic              initHold;
  logic [DATA_W-1:0] rdVal;

  hostlink_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostSel(hostSel),
    .initHold(initHold), .reqDone(reqDone), .strb(strb), .reqValid(reqValid)
  );

  hostlink_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IPL_W(IPL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostSel(hostSel), .busIn(hostData),
    .irqLevel(irqLevel), .reqRdata(reqRdata), .rdVal(rdVal),
    .initHold(initHold), .busReset(busReset), .iplZero(iplZero),
    .reqWrite(reqWrite), .reqByte(reqByte), .reqLanes(reqLanes),
    .reqAddr(reqAddr), .reqWdata(reqWdata)
  );

  assign xferBusy = reqValid;
  assign hostData = hostRd ? rdVal : {DATA_W{1'bz}};
endmodule

// File: rtl/hostlink_bridge_chk.sv
module hostlink_bridge_chk
  import hostlink_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input strobeT            strb,
  input logic              initHold,
  input logic              reqValid,
  input logic              xferBusy,
  input logic              reqDone,
  input logic              reqWrite,
  input logic              reqByte,
  input logic [1:0]        reqLanes,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata
);
  // R2: a request only appears after an accepted address-high load
  a_r2_launch_from_hi: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) |-> $past(strb.ldHi));

  // R4: a byte access enables one lane, a word access both
  a_r4_lane_count: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ($countones(reqLanes) == (reqByte ? 1 : 2)));

  // R5: request fields hold until completion
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqDone && !initHold) |=> (reqValid && $stable(reqAddr)
      && $stable(reqWrite) && $stable(reqByte) && $stable(reqWdata)));

  // R5: completion clears busy on the next cycle
  a_r5_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDone) |=> !xferBusy);

  // R7: no data or address loads while busy
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !(strb.ldData || strb.ldLo || strb.ldHi));

  // R10: init bit forces the engine idle
  a_r10_init_idle: assert property (@(posedge clk) disable iff (!rstN)
    initHold |=> !reqValid);
endmodule

bind hostlink_bridge hostlink_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .initHold(initHold),
  .reqValid(reqValid), .xferBusy(xferBusy), .reqDone(reqDone),
  .reqWrite(reqWrite), .reqByte(reqByte), .reqLanes(reqLanes),
  .reqAddr(reqAddr), .reqWdata(reqWdata)
);

// File: tb/test_hostlink_bridge.sv
module test_hostlink_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic        tbDrv = 1'b0;
  logic [15:0] tbVal = 16'd0;
  wire  [15:0] hostData;
  logic        xferBusy, iplZero, busReset, reqValid, reqWrite, reqByte;
  logic [2:0]  irqLevel = 3'd0;
  logic [1:0]  reqLanes;
  logic [23:0] reqAddr;
  logic [15:0] reqWdata, reqRdata = 16'd0;
  logic        reqDone = 1'b0;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  assign hostData = tbDrv ? tbVal : 16'bz;

  always #2 clk = ~clk;

  hostlink_bridge i_hostlink_bridge (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr), .hostRd(hostRd),
    .hostData(hostData), .xferBusy(xferBusy), .iplZero(iplZero),
    .irqLevel(irqLevel), .busReset(busReset), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqByte(reqByte), .reqLanes(reqLanes),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqDone(reqDone), .reqRdata(reqRdata)
  );

  function automatic logic [1:0] expLanes(input logic isByte, input logic a0);
    if (!isByte) return 2'b11;
    return a0 ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [15:0] expStatus(input logic [2:0] ipl, input logic rst, input logic ini);
    return {ipl, 11'd0, rst, ini};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    hostSel = sel; tbVal = val; tbDrv = 1'b1; hostWr = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    hostWr = 1'b0; tbDrv = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    hostSel = sel; hostRd = 1'b1;
    #1 val = hostData;
    hostRd = 1'b0;
  endtask

  task automatic complete(input logic [15:0] rd);
    @(negedge clk);
    reqDone = 1'b1; reqRdata = rd;
    @(posedge clk);
    @(negedge clk);
    reqDone = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    check("R12 busy", xferBusy, 0);
    check("R12 valid", reqValid, 0);
    check("R12 busReset", busReset, 0);
    hostRead(2'd1, v); check("R12 addrLo", v, 0);
    hostRead(2'd3, v); check("R12 status", v, 0);
    // R9 interrupt level zero flag
    check("R9 zero", iplZero, 1);
    irqLevel = 3'd5; #1;
    check("R9 nonzero", iplZero, 0);
    // R8 status read
    hostRead(2'd3, v); check("R8 status ipl", v, expStatus(3'd5, 0, 0));
    // R1 register load and readback
    hostWrite(2'd1, 16'hbeef);
    hostRead(2'd1, v); check("R1 addrLo", v, 16'hbeef);
    check("R1 no launch", xferBusy, 0);
    // R2 launch timing: three edges after the strobe
    @(negedge clk);
    hostSel = 2'd2; tbVal = 16'h0012; tbDrv = 1'b1; hostWr = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check("R2 not yet busy", xferBusy, 0);
    @(posedge clk); @(negedge clk);
    check("R2 busy", xferBusy, 1);
    check("R2 addr", reqAddr, 24'h12beef);
    check("R3 word write", {reqWrite, reqByte}, 2'b10);
    check("R4 word lanes", reqLanes, 2'b11);
    hostWr = 1'b0; tbDrv = 1'b0;
    repeat (3) @(posedge clk); @(negedge clk);
    // R7 writes while busy ignored
    hostWrite(2'd1, 16'h1234);
    hostRead(2'd1, v); check("R7 addrLo kept", v, 16'hbeef);
    check("R5 still busy", xferBusy, 1);
    check("R5 addr stable", reqAddr, 24'h12beef);
    // R11 control write accepted while busy
    hostWrite(2'd3, 16'h0002);
    check("R11 busReset set", busReset, 1);
    check("R11 busy kept", xferBusy, 1);
    complete(16'h0);
    check("R5 done clears", xferBusy, 0);
    hostRead(2'd3, v); check("R8 status bits", v, expStatus(3'd5, 1, 0));
    hostWrite(2'd3, 16'h0000);
    check("R11 busReset clear", busReset, 0);
    // R10 init holds idle
    hostWrite(2'd3, 16'h0001);
    hostRead(2'd3, v); check("R10 init bit", v, expStatus(3'd5, 0, 1));
    hostWrite(2'd2, 16'h0200);
    check("R10 no launch", xferBusy, 0);
    hostWrite(2'd3, 16'h0000);
    check("R10 stays idle", xferBusy, 0);
    hostWrite(2'd2, 16'h0300);
    check("R10 launch after clear", xferBusy, 1);
    hostWrite(2'd3, 16'h0001);
    check("R10 abort", xferBusy, 0);
    hostWrite(2'd3, 16'h0000);
    // R4 byte lanes directed
    hostWrite(2'd1, 16'h0010);
    hostWrite(2'd2, 16'h0100);
    check("R4 even byte", reqLanes, 2'b10);
    complete(16'h0);
    hostWrite(2'd1, 16'h0011);
    hostWrite(2'd2, 16'h0100);
    check("R4 odd byte", reqLanes, 2'b01);
    complete(16'h0);
    // random transactions
    for (int i = 0; i < 40; i++) begin
      logic [23:0] a;
      logic [15:0] d, rdat;
      logic isByte, isRead;
      a = 24'($urandom); d = 16'($urandom); rdat = 16'($urandom);
      isByte = 1'($urandom); isRead = 1'($urandom);
      if (!isRead) hostWrite(2'd0, isByte ? {d[7:0], d[7:0]} : d);
      hostWrite(2'd1, a[15:0]);
      hostWrite(2'd2, {6'd0, isRead, isByte, a[23:16]});
      check("R2 rand busy", reqValid, 1);
      check("R2 rand addr", reqAddr, a);
      check("R3 rand flags", {reqWrite, reqByte}, {~isRead, isByte});
      check("R4 rand lanes", reqLanes, expLanes(isByte, a[0]));
      if (!isRead) check("R3 rand wdata", reqWdata, isByte ? {d[7:0], d[7:0]} : d);
      repeat ($urandom_range(0, 4)) @(negedge clk);
      check("R5 rand hold", xferBusy, 1);
      complete(rdat);
      check("R5 rand done", xferBusy, 0);
      if (isRead) begin
        hostRead(2'd0, v);
        check("R6 rand rdata", v, rdat);
      end
    end
    summary();
  end
endmodule